// File: doc/BRIEF.md
# Integer ALU with Operand and Result Negate/Invert Controls

This block is a registered integer ALU. Each source operand, and the result, can pass unchanged, be bit-inverted or be two's-complement negated. Every operation runs on a single carry-propagate adder. The operand controls are an XOR mask plus a carry increment, so subtract is an add with the second operand inverted and a carry-in. Reverse subtract inverts the first operand instead. A separate compare subtractor runs in parallel with the main adder. It gives equality and both signed and unsigned greater-than flags. Those flags also drive the select for signed and unsigned MIN and MAX.

The arithmetic operations carry a mode. The mode selects wrapping, trapping on signed or unsigned overflow, or clamping to the signed or unsigned range. A short-form path adds or subtracts a 4-bit constant in the range 1 to 16 to or from the first operand, for stepping through arrays. One valid-qualified input beat produces one output beat on the next clock.

Top module: `ona_alu`

## Requirements
- R1: While reset (rst_ni low) is asserted, valid_o, trap_o, res_o, eq_o, gts_o and gtu_o are all zero.
- R2: valid_o is high exactly in the cycle after a cycle with valid_i high. An accepted beat's result and flags appear in that same cycle.
- R3: Operand modifier codes (amod_i, bmod_i) are: 0 = pass, 1 = bitwise invert, 2 = two's-complement negate modulo 2^W, 3 = pass. The delivered operands are called P (from a_i) and Q (from b_i).
- R4: Opcode 0 gives P+Q, opcode 1 gives P-Q and opcode 2 gives Q-P, each modulo 2^W in wrap mode.
- R5: The result modifier rmod_i uses the same codes as R3 and is applied last, after the operation and any clamping.
- R6: Opcodes 3, 4 and 5 give P AND Q, P OR Q and P XOR Q. Opcodes 12 to 15 give zero before the result modifier.
- R7: For every opcode, eq_o = (P == Q), gts_o = (P > Q) signed and gtu_o = (P > Q) unsigned.
- R8: Opcodes 6, 7, 8 and 9 give the signed minimum, signed maximum, unsigned minimum and unsigned maximum of P and Q.
- R9: Opcode 10 gives P+T and opcode 11 gives P-T. T is tiny_i read as 1 to 15, with tiny_i = 0 meaning 16.
- R10: The arithmetic modes are mode_i = 1 (trap on signed overflow) and 2 (trap on unsigned overflow or borrow). In these modes the wrapped result is written and trap_o is high for that one output beat only.
- R11: Mode 3 clamps a signed overflow to the signed maximum or minimum. Mode 4 clamps an unsigned overflow to all-ones and a borrow to zero. trap_o stays low in both.
- R12: Mode 0 (and the unused codes 5 to 7) wraps, and never raises trap_o. Non-arithmetic opcodes never raise trap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input beat valid |
| op_i | input | 4 | Opcode |
| a_i | input | W | First operand (register or pre-extended immediate) |
| b_i | input | W | Second operand |
| amod_i | input | 2 | First operand modifier |
| bmod_i | input | 2 | Second operand modifier |
| rmod_i | input | 2 | Result modifier |
| mode_i | input | 3 | Arithmetic mode: wrap, trap or saturate |
| tiny_i | input | 4 | Short-form constant, 0 meaning 16 |
| valid_o | output | 1 | Output beat valid |
| res_o | output | W | Result |
| trap_o | output | 1 | Overflow trap pulse |
| eq_o | output | 1 | P equals Q |
| gts_o | output | 1 | P greater than Q, signed |
| gtu_o | output | 1 | P greater than Q, unsigned |

## Verification
The datapath holds no state between beats. A wrong carry-in, a wrong mask or a wrong mux select therefore shows at res_o or the flags on the very beat that uses it, one clock after valid_i. Faults in the operand path also show in the compare flags, because the compare subtractor sees the delivered operands independently of the opcode. A flaw in the output register shows as trap_o or valid_o that lingers into a following idle cycle.

// File: rtl/ona_pkg.sv
package ona_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_RSUB = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_MINS = 4'd6,
      OP_MAXS = 4'd7,
      OP_MINU = 4'd8,
      OP_MAXU = 4'd9,
      OP_TADD = 4'd10,
      OP_TSUB = 4'd11
   } ona_op_e;

   localparam logic [1:0] MOD_PASS = 2'd0;
   localparam logic [1:0] MOD_INV  = 2'd1;
   localparam logic [1:0] MOD_NEG  = 2'd2;

   localparam logic [2:0] AM_WRAP   = 3'd0;
   localparam logic [2:0] AM_TRAP_S = 3'd1;
   localparam logic [2:0] AM_TRAP_U = 3'd2;
   localparam logic [2:0] AM_SAT_S  = 3'd3;
   localparam logic [2:0] AM_SAT_U  = 3'd4;
endpackage

// File: rtl/ona_deliver.sv
module ona_deliver
   import ona_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] d_i,
   input  logic [1:0]   mod_i,
   output logic [W-1:0] d_o
);
   logic          flip;
   logic [W-1:0]  masked;

   always_comb begin
      flip   = (mod_i == MOD_INV) || (mod_i == MOD_NEG);
      masked = d_i ^ {W{flip}};
      d_o    = masked + {{(W-1){1'b0}}, (mod_i == MOD_NEG)};
   end
endmodule

// File: rtl/ona_addcore.sv
module ona_addcore #(
   parameter int W = 64
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         sov_o
);
   always_comb begin
      {cout_o, sum_o} = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      sov_o = (x_i[W-1] == y_i[W-1]) && (sum_o[W-1] != x_i[W-1]);
   end
endmodule

// File: rtl/ona_clamp.sv
module ona_clamp
   import ona_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] sum_i,
   input  logic         sov_i,
   input  logic         uov_i,
   input  logic         xsign_i,
   input  logic         is_sub_i,
   input  logic         is_arith_i,
   input  logic [2:0]   mode_i,
   output logic [W-1:0] r_o,
   output logic         trap_o
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      r_o    = sum_i;
      trap_o = 1'b0;
      if (is_arith_i) begin
         unique case (mode_i)
            AM_TRAP_S: trap_o = sov_i;
            AM_TRAP_U: trap_o = uov_i;
            AM_SAT_S:  if (sov_i) r_o = xsign_i ? SMIN : SMAX;
            AM_SAT_U:  if (uov_i) r_o = is_sub_i ? '0 : '1;
            default:   r_o = sum_i;
         endcase
      end
   end
endmodule

// File: rtl/ona_alu.sv
module ona_alu
   import ona_pkg::*;
#(
   parameter int W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         valid_i,
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   amod_i,
   input  logic [1:0]   bmod_i,
   input  logic [1:0]   rmod_i,
   input  logic [2:0]   mode_i,
   input  logic [3:0]   tiny_i,
   output logic         valid_o,
   output logic [W-1:0] res_o,
   output logic         trap_o,
   output logic         eq_o,
   output logic         gts_o,
   output logic         gtu_o
);
   localparam int NOPD = 2;
   localparam int TW   = 5;

   if (W < 8) begin : g_width_check
      $error("ona_alu: W must be at least 8");
   end

   logic [NOPD-1:0][W-1:0] raw, dlv;
   logic [NOPD-1:0][1:0]   mods;
   assign raw  = {b_i, a_i};
   assign mods = {bmod_i, amod_i};

   for (genvar k = 0; k < NOPD; k++) begin : g_opnd
      ona_deliver #(.W(W)) u_dlv (.d_i(raw[k]), .mod_i(mods[k]), .d_o(dlv[k]));
   end

   logic [W-1:0] p, q, tval;
   assign p = dlv[0];
   assign q = dlv[1];
   assign tval = (tiny_i == 4'd0) ? W'(5'd16) : W'({{(TW-4){1'b0}}, tiny_i});

   ona_op_e      op;
   logic [W-1:0] ax, ay;
   logic         acin, is_sub, is_arith;

   always_comb begin
      op       = ona_op_e'(op_i);
      ax       = p;
      ay       = q;
      acin     = 1'b0;
      is_sub   = 1'b0;
      is_arith = 1'b1;
      case (op)
         OP_ADD:  ;
         OP_SUB:  begin ay = ~q; acin = 1'b1; is_sub = 1'b1; end
         OP_RSUB: begin ax = ~p; acin = 1'b1; is_sub = 1'b1; end
         OP_TADD: ay = tval;
         OP_TSUB: begin ay = ~tval; acin = 1'b1; is_sub = 1'b1; end
         default: is_arith = 1'b0;
      endcase
   end

   logic [W-1:0] asum, dsum;
   logic         acout, asov, dcout, dsov;

   ona_addcore #(.W(W)) u_arith (
      .x_i(ax), .y_i(ay), .cin_i(acin),
      .sum_o(asum), .cout_o(acout), .sov_o(asov));

   ona_addcore #(.W(W)) u_cmp (
      .x_i(p), .y_i(~q), .cin_i(1'b1),
      .sum_o(dsum), .cout_o(dcout), .sov_o(dsov));

   logic eq_c, gts_c, gtu_c, uov;
   always_comb begin
      eq_c  = (dsum == '0);
      gtu_c = dcout && !eq_c;
      gts_c = !(dsum[W-1] ^ dsov) && !eq_c;
      uov   = is_sub ? !acout : acout;
   end

   logic [W-1:0] arith_r, pre_r, fin_r;
   logic         trap_c;

   ona_clamp #(.W(W)) u_clamp (
      .sum_i(asum), .sov_i(asov), .uov_i(uov), .xsign_i(ax[W-1]),
      .is_sub_i(is_sub), .is_arith_i(is_arith), .mode_i(mode_i),
      .r_o(arith_r), .trap_o(trap_c));

   always_comb begin
      case (op)
         OP_AND:  pre_r = p & q;
         OP_OR:   pre_r = p | q;
         OP_XOR:  pre_r = p ^ q;
         OP_MINS: pre_r = gts_c ? q : p;
         OP_MAXS: pre_r = gts_c ? p : q;
         OP_MINU: pre_r = gtu_c ? q : p;
         OP_MAXU: pre_r = gtu_c ? p : q;
         default: pre_r = is_arith ? arith_r : '0;
      endcase
   end

   ona_deliver #(.W(W)) u_rdlv (.d_i(pre_r), .mod_i(rmod_i), .d_o(fin_r));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         trap_o  <= 1'b0;
         res_o   <= '0;
         eq_o    <= 1'b0;
         gts_o   <= 1'b0;
         gtu_o   <= 1'b0;
      end else begin
         valid_o <= valid_i;
         trap_o  <= valid_i && trap_c;
         if (valid_i) begin
            res_o <= fin_r;
            eq_o  <= eq_c;
            gts_o <= gts_c;
            gtu_o <= gtu_c;
         end
      end
   end
endmodule

// File: rtl/ona_alu_chk.sv
module ona_alu_chk
   import ona_pkg::*;
#(
   parameter int W = 64
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         valid_i,
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic [1:0]   amod_i,
   input logic [1:0]   bmod_i,
   input logic [2:0]   mode_i,
   input logic         valid_o,
   input logic         trap_o,
   input logic         eq_o,
   input logic         gts_o,
   input logic         gtu_o
);
   // R1: reset clears the output beat
   p_rst_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (!valid_o && !trap_o));

   // R2: one-cycle latency of valid
   p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
   p_idle_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);

   // R10: trap only accompanies a valid beat and lasts one beat
   p_trap_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> valid_o);
   p_trap_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_o && !valid_i) |=> !trap_o);

   // R11, R12: wrap and saturate modes never trap
   p_no_trap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (mode_i == AM_WRAP || mode_i == AM_SAT_S || mode_i == AM_SAT_U))
      |=> !trap_o);

   // R7: identical delivered operands compare equal; flags are exclusive with eq
   p_eq_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && a_i == b_i && amod_i == bmod_i) |=> eq_o);
   p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && eq_o) |-> (!gts_o && !gtu_o));
endmodule

bind ona_alu ona_alu_chk #(.W(W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
   .a_i(a_i), .b_i(b_i), .amod_i(amod_i), .bmod_i(bmod_i), .mode_i(mode_i),
   .valid_o(valid_o), .trap_o(trap_o), .eq_o(eq_o), .gts_o(gts_o), .gtu_o(gtu_o));

// File: tb/sim_ona_alu.sv
`timescale 1ns/1ps
module sim_ona_alu;
   localparam int BW = 8;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          valid_i = 1'b0;
   logic [3:0]    op_i = '0;
   logic [BW-1:0] a_i = '0, b_i = '0;
   logic [1:0]    amod_i = '0, bmod_i = '0, rmod_i = '0;
   logic [2:0]    mode_i = '0;
   logic [3:0]    tiny_i = '0;
   logic          valid_o, trap_o, eq_o, gts_o, gtu_o;
   logic [BW-1:0] res_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk_i = ~clk_i;

   ona_alu #(.W(BW)) u0 (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .amod_i(amod_i), .bmod_i(bmod_i), .rmod_i(rmod_i),
      .mode_i(mode_i), .tiny_i(tiny_i), .valid_o(valid_o), .res_o(res_o),
      .trap_o(trap_o), .eq_o(eq_o), .gts_o(gts_o), .gtu_o(gtu_o));

   function automatic int sx(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // R3 and R5 modifier codes
   function automatic int dl(input int v, input int m);
      if (m == 1) return (~v) & 255;
      if (m == 2) return (256 - v) & 255;
      return v;
   endfunction

   function automatic int vsel(input int i);
      case (i)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0f;
         4: return 8'h10;  5: return 8'h3c;  6: return 8'h55;  7: return 8'h7e;
         8: return 8'h7f;  9: return 8'h80; 10: return 8'h81; 11: return 8'haa;
        12: return 8'hc3; 13: return 8'hf0; 14: return 8'hfe; default: return 8'hff;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input int op, input int a, input int b, input int am,
                          input int bm, input int rm, input int md, input int tn);
      int p, q, t, r, tr, eq, gs, gu, sr, ur, ar;
      bit sov, uov;
      string tag;
      p = dl(a, am); q = dl(b, bm); t = (tn == 0) ? 16 : tn;
      eq = (p == q); gs = (sx(p) > sx(q)); gu = (p > q);
      ar = 1; sr = 0; ur = 0; tr = 0; r = 0;
      case (op)
         0: begin sr = sx(p) + sx(q); ur = p + q; end
         1: begin sr = sx(p) - sx(q); ur = p - q; end
         2: begin sr = sx(q) - sx(p); ur = q - p; end
         10: begin sr = sx(p) + t; ur = p + t; end
         11: begin sr = sx(p) - t; ur = p - t; end
         default: ar = 0;
      endcase
      if (ar == 1) begin
         sov = (sr > 127) || (sr < -128);
         uov = (ur > 255) || (ur < 0);
         r = ur & 255;
         case (md)
            1: tr = sov;
            2: tr = uov;
            3: if (sov) r = (sr > 0) ? 127 : 128;
            4: if (uov) r = (ur > 0) ? 255 : 0;
            default: tr = 0;
         endcase
      end else begin
         case (op)
            3: r = p & q;
            4: r = p | q;
            5: r = p ^ q;
            6: r = (sx(p) < sx(q)) ? p : q;
            7: r = (sx(p) > sx(q)) ? p : q;
            8: r = (p < q) ? p : q;
            9: r = (p > q) ? p : q;
            default: r = 0;
         endcase
      end
      r = dl(r, rm);
      if (ar == 1 && (md == 3 || md == 4)) tag = "R11";
      else if (op == 10 || op == 11) tag = "R9";
      else if (ar == 1) tag = "R4";
      else if (op >= 6 && op <= 9) tag = "R8";
      else tag = "R6";
      @(negedge clk_i);
      valid_i = 1'b1; op_i = 4'(op); a_i = 8'(a); b_i = 8'(b);
      amod_i = 2'(am); bmod_i = 2'(bm); rmod_i = 2'(rm);
      mode_i = 3'(md); tiny_i = 4'(tn);
      @(posedge clk_i); #1;
      check({tag, " result (R3 R5 modifiers)"}, int'(res_o), r);
      check((md == 1 || md == 2) ? "R10 trap" : "R12 trap", int'(trap_o), tr);
      check("R7 flags", {eq_o, gts_o, gtu_o}, {eq[0], gs[0], gu[0]});
      check("R2 valid", int'(valid_o), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      #1;
      check("R1 reset outputs", {valid_o, trap_o, eq_o, gts_o, gtu_o, res_o}, 0);
      @(negedge clk_i) rst_ni = 1'b1;

      // R10: trap then idle, trap must not persist
      run_vec(0, 8'h7f, 8'h01, 0, 0, 0, 1, 0);
      @(negedge clk_i) valid_i = 1'b0;
      @(posedge clk_i); #1;
      check("R10 trap pulse", int'(trap_o), 0);
      check("R2 idle valid", int'(valid_o), 0);
      // R9: tiny 0 means 16
      run_vec(10, 8'h00, 8'h00, 0, 0, 0, 0, 0);
      run_vec(11, 8'h20, 8'h00, 0, 0, 0, 0, 0);
      // R6: reserved opcodes give zero before the result modifier
      run_vec(13, 8'h5a, 8'h33, 0, 0, 1, 0, 3);

      for (int op = 0; op < 12; op++)
         for (int am = 0; am < 3; am++)
            for (int bm = 0; bm < 3; bm++)
               for (int rm = 0; rm < 3; rm++)
                  for (int i = 0; i < 16; i++)
                     for (int j = 0; j < 16; j++)
                        run_vec(op, vsel(i), vsel(j), am, bm, rm,
                                (i + j + rm) % 5, (i * 3 + j) % 16);

      // R3: modifier code 3 behaves as pass
      run_vec(0, 8'h12, 8'h34, 3, 3, 3, 0, 1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule